// File: doc/BRIEF.md
# Unaligned Vector Partial-Store Unit

This block executes the two halves of an unaligned 128-bit vector store. One instruction stores the left half and another stores the right half. Both come in a classic 32-register encoding and an extended 128-register encoding, and each has a cache-hint twin that stores the same data. The unit decodes the instruction word and drives the register-file read indices. It forms the effective address (EA) from two general registers. It then issues a single aligned 16-byte write, with a byte-enable mask and with the source vector rotated into place.

The address is never rounded down before use. Its low four bits, `s = EA mod 16`, set how many vector bytes leave the unit and where in the aligned block they land. A left store at EA followed by a right store at EA+16 writes the whole vector to EA. The two writes cover disjoint bytes, so their order does not matter.

The control is a three-state machine:
- `ST_IDLE`: waits for `start_i` and latches the decoded operation, the EA and the vector.
- `ST_ISSUE`: holds `wr_req_o` until `wr_ack_i`.
- `ST_DONE`: pulses `done_o` for one cycle.

The transitions are:
- IDLE→ISSUE on a start that needs a write.
- IDLE→DONE on a start that writes nothing: an unrecognised word, or a right store with s=0.
- ISSUE→DONE on acknowledge.
- DONE→IDLE always.

Top module: `vps_unit`

## Requirements
- R1: Classic forms have primary opcode 31 in instr[31:26], the extended opcode in instr[10:1] and instr[0]=0. Value 647 is store-left, 903 is hinted store-left, 679 is store-right and 935 is hinted store-right. `vr_idx_o` = {2'b00, instr[25:21]}.
- R2: Extended forms have primary opcode 4 in instr[31:26] and the extended opcode in instr[10:4]. Value 80 is store-left, 112 is hinted store-left, 84 is store-right and 116 is hinted store-right. `vr_idx_o` = {instr[3:2], instr[25:21]}, which covers registers 0 to 127.
- R3: `gpr_a_idx_o` = instr[20:16] and `gpr_b_idx_o` = instr[15:11]. EA = (gpr_a_idx_o==0 ? 0 : ra_val_i) + rb_val_i, modulo 2^64. `wr_addr_o` = EA with bits [3:0] cleared.
- R4: In the write port, `wr_be_o[i]` enables the byte at `wr_addr_o`+i, and that byte is carried in `wr_data_o[127-8i -: 8]`. A store-left enables exactly the bytes i >= s.
- R5: A store-right enables exactly the bytes i < s. When s=0 it issues no write and `done_o` still pulses.
- R6: The byte at `wr_addr_o`+i carries vector byte (i-s) mod 16. Vector byte 0 is `vr_data_i[127:120]`.
- R7: A hinted variant produces the same request as its plain variant.
- R8: `wr_req_o` stays high, with address, mask and data stable, until `wr_ack_i`. `done_o` is high for exactly one cycle, in the cycle after the acknowledging edge.
- R9: An unrecognised instruction word causes no write. `done_o` pulses together with `illegal_o`.
- R10: `start_i` is ignored outside `ST_IDLE`.
- R11: A store-left at EA and a store-right at EA+16 write disjoint bytes that together place all 16 vector bytes at EA..EA+15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse; accepted only in ST_IDLE |
| instr_i | input | 32 | Instruction word |
| ra_val_i | input | 64 | Value of general register gpr_a_idx_o |
| rb_val_i | input | 64 | Value of general register gpr_b_idx_o |
| vr_data_i | input | 128 | Value of vector register vr_idx_o |
| gpr_a_idx_o | output | 5 | Base register index |
| gpr_b_idx_o | output | 5 | Offset register index |
| vr_idx_o | output | 7 | Source vector register index |
| wr_req_o | output | 1 | Write request |
| wr_addr_o | output | 64 | Aligned write address |
| wr_be_o | output | 16 | Byte enables |
| wr_data_o | output | 128 | Rotated write data |
| wr_ack_i | input | 1 | Write accepted |
| done_o | output | 1 | Operation complete pulse |
| illegal_o | output | 1 | Completed instruction was not recognised |

## Verification
A new start can arrive in the same cycle that the write is acknowledged, or while the done pulse is out. The first case is a start coinciding with completion of the previous operation. The bench holds `start_i` high, with a different valid instruction, across the acknowledge cycle and the done cycle. After `done_o` it checks that no further write request or done pulse appears. It also sweeps every offset, every opcode variant and both encodings against an arithmetic model. It then replays left/right pairs into a byte-array memory to confirm that they are disjoint and complete.

// File: rtl/vps_pkg.sv
package vps_pkg;
    localparam int unsigned ADDR_W    = 64;
    localparam int unsigned VEC_BYTES = 16;
    localparam int unsigned VEC_W     = VEC_BYTES * 8;
    localparam int unsigned OFF_W     = $clog2(VEC_BYTES);

    localparam logic [5:0] PRI_CLASSIC = 6'd31;
    localparam logic [5:0] PRI_EXT     = 6'd4;

    localparam logic [9:0] XC_LEFT     = 10'd647;
    localparam logic [9:0] XC_LEFT_H   = 10'd903;
    localparam logic [9:0] XC_RIGHT    = 10'd679;
    localparam logic [9:0] XC_RIGHT_H  = 10'd935;

    localparam logic [6:0] XE_LEFT     = 7'd80;
    localparam logic [6:0] XE_LEFT_H   = 7'd112;
    localparam logic [6:0] XE_RIGHT    = 7'd84;
    localparam logic [6:0] XE_RIGHT_H  = 7'd116;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_LEFT  = 2'd1,
        OP_RIGHT = 2'd2
    } op_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DONE  = 2'd2
    } state_e;
endpackage

// File: rtl/vps_decode.sv
module vps_decode
    import vps_pkg::*;
(
    input  logic [31:0] instr_i,
    output op_kind_e    kind_o,
    output logic [6:0]  vr_idx_o,
    output logic [4:0]  ra_idx_o,
    output logic [4:0]  rb_idx_o
);
    logic [5:0] primary;
    logic [9:0] xo_classic;
    logic [6:0] xo_ext;
    logic       rc_bit;
    logic       is_classic;
    logic       is_ext;
    op_kind_e   kind_classic;
    op_kind_e   kind_ext;

    assign primary    = instr_i[31:26];
    assign xo_classic = instr_i[10:1];
    assign xo_ext     = instr_i[10:4];
    assign rc_bit     = instr_i[0];
    assign is_classic = (primary == PRI_CLASSIC) && !rc_bit;
    assign is_ext     = (primary == PRI_EXT);

    always_comb begin
        unique case (xo_classic)
            XC_LEFT, XC_LEFT_H:   kind_classic = OP_LEFT;
            XC_RIGHT, XC_RIGHT_H: kind_classic = OP_RIGHT;
            default:              kind_classic = OP_NONE;
        endcase
    end

    always_comb begin
        unique case (xo_ext)
            XE_LEFT, XE_LEFT_H:   kind_ext = OP_LEFT;
            XE_RIGHT, XE_RIGHT_H: kind_ext = OP_RIGHT;
            default:              kind_ext = OP_NONE;
        endcase
    end

    always_comb begin
        kind_o   = OP_NONE;
        vr_idx_o = {2'b00, instr_i[25:21]};
        if (is_classic) begin
            kind_o = kind_classic;
        end else if (is_ext) begin
            kind_o   = kind_ext;
            vr_idx_o = {instr_i[3:2], instr_i[25:21]};
        end
    end

    assign ra_idx_o = instr_i[20:16];
    assign rb_idx_o = instr_i[15:11];
endmodule

// File: rtl/vps_agu.sv
module vps_agu
    import vps_pkg::*;
(
    input  logic [4:0]        ra_idx_i,
    input  logic [ADDR_W-1:0] ra_val_i,
    input  logic [ADDR_W-1:0] rb_val_i,
    output logic [ADDR_W-1:0] ea_o
);
    logic [ADDR_W-1:0] base;

    assign base = (ra_idx_i == 5'd0) ? '0 : ra_val_i;
    assign ea_o = base + rb_val_i;
endmodule

// File: rtl/vps_lane.sv
module vps_lane
    import vps_pkg::*;
(
    input  op_kind_e         kind_i,
    input  logic [OFF_W-1:0] off_i,
    input  logic [VEC_W-1:0] vec_i,
    output logic [VEC_BYTES-1:0] be_o,
    output logic [VEC_W-1:0] data_o
);
    genvar gi;
    generate
        for (gi = 0; gi < VEC_BYTES; gi++) begin : g_byte
            logic [OFF_W-1:0] src;
            logic             at_or_above;
            assign src         = OFF_W'(gi) - off_i;
            assign at_or_above = (OFF_W'(gi) >= off_i);
            assign data_o[VEC_W-1-8*gi -: 8] = vec_i[VEC_W-1-8*src -: 8];
            always_comb begin
                unique case (kind_i)
                    OP_LEFT:  be_o[gi] = at_or_above;
                    OP_RIGHT: be_o[gi] = !at_or_above;
                    default:  be_o[gi] = 1'b0;
                endcase
            end
        end
    endgenerate
endmodule

// File: rtl/vps_unit.sv
module vps_unit
    import vps_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [31:0]   instr_i,
    input  logic [63:0]   ra_val_i,
    input  logic [63:0]   rb_val_i,
    input  logic [127:0]  vr_data_i,
    output logic [4:0]    gpr_a_idx_o,
    output logic [4:0]    gpr_b_idx_o,
    output logic [6:0]    vr_idx_o,
    output logic          wr_req_o,
    output logic [63:0]   wr_addr_o,
    output logic [15:0]   wr_be_o,
    output logic [127:0]  wr_data_o,
    input  logic          wr_ack_i,
    output logic          done_o,
    output logic          illegal_o
);
    op_kind_e          dec_kind;
    logic [ADDR_W-1:0] ea;

    state_e            state_q, state_d;
    op_kind_e          kind_q;
    logic [ADDR_W-1:0] ea_q;
    logic [VEC_W-1:0]  vec_q;
    logic              needs_write;

    vps_decode u_dec (
        .instr_i  (instr_i),
        .kind_o   (dec_kind),
        .vr_idx_o (vr_idx_o),
        .ra_idx_o (gpr_a_idx_o),
        .rb_idx_o (gpr_b_idx_o)
    );

    vps_agu u_agu (
        .ra_idx_i (gpr_a_idx_o),
        .ra_val_i (ra_val_i),
        .rb_val_i (rb_val_i),
        .ea_o     (ea)
    );

    vps_lane u_lane (
        .kind_i (kind_q),
        .off_i  (ea_q[OFF_W-1:0]),
        .vec_i  (vec_q),
        .be_o   (wr_be_o),
        .data_o (wr_data_o)
    );

    assign needs_write = (dec_kind == OP_LEFT) ||
                         ((dec_kind == OP_RIGHT) && (ea[OFF_W-1:0] != '0));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = needs_write ? ST_ISSUE : ST_DONE;
            ST_ISSUE: if (wr_ack_i) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            kind_q  <= OP_NONE;
            ea_q    <= '0;
            vec_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start_i) begin
                kind_q <= dec_kind;
                ea_q   <= ea;
                vec_q  <= vr_data_i;
            end
        end
    end

    always_comb begin
        wr_req_o  = 1'b0;
        done_o    = 1'b0;
        illegal_o = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_ISSUE: wr_req_o = 1'b1;
            ST_DONE: begin
                done_o    = 1'b1;
                illegal_o = (kind_q == OP_NONE);
            end
            default:  ;
        endcase
    end

    assign wr_addr_o = {ea_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o && !wr_ack_i |=> wr_req_o && $stable(wr_addr_o) && $stable(wr_be_o) && $stable(wr_data_o)); // R8
    AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o && wr_ack_i |=> done_o && !wr_req_o); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o && !wr_req_o); // R10
    AST_MASK_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o && kind_q == OP_LEFT |-> $countones(wr_be_o) == 32'(VEC_BYTES) - 32'(ea_q[OFF_W-1:0])); // R4
    AST_MASK_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o && kind_q == OP_RIGHT |-> $countones(wr_be_o) == 32'(ea_q[OFF_W-1:0]) && wr_be_o[0]); // R5
    AST_NO_ILLEGAL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o |-> kind_q != OP_NONE && wr_be_o != '0); // R9
endmodule

// File: tb/tb_vps_unit.sv
`timescale 1ns/1ps
module tb_vps_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [31:0]  instr_i = '0;
    logic [63:0]  ra_val_i = '0;
    logic [63:0]  rb_val_i = '0;
    logic [127:0] vr_data_i = '0;
    logic [4:0]   gpr_a_idx_o, gpr_b_idx_o;
    logic [6:0]   vr_idx_o;
    logic         wr_req_o;
    logic [63:0]  wr_addr_o;
    logic [15:0]  wr_be_o;
    logic [127:0] wr_data_o;
    logic         wr_ack_i = 1'b0;
    logic         done_o, illegal_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [7:0] mem [0:63];
    int         wcount [0:63];

    always #5 clk = ~clk;

    vps_unit dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .instr_i(instr_i),
        .ra_val_i(ra_val_i), .rb_val_i(rb_val_i), .vr_data_i(vr_data_i),
        .gpr_a_idx_o(gpr_a_idx_o), .gpr_b_idx_o(gpr_b_idx_o), .vr_idx_o(vr_idx_o),
        .wr_req_o(wr_req_o), .wr_addr_o(wr_addr_o), .wr_be_o(wr_be_o),
        .wr_data_o(wr_data_o), .wr_ack_i(wr_ack_i), .done_o(done_o), .illegal_o(illegal_o)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_c(input logic [9:0] xo, input logic [4:0] vs, input logic [4:0] ra, input logic [4:0] rb);
        return {6'd31, vs, ra, rb, xo, 1'b0};
    endfunction

    function automatic logic [31:0] enc_e(input logic [6:0] xo, input logic [6:0] vd, input logic [4:0] ra, input logic [4:0] rb);
        return {6'd4, vd[4:0], ra, rb, xo, vd[6:5], 2'b11};
    endfunction

    function automatic logic [127:0] mkvec(input int seed);
        logic [127:0] v;
        for (int j = 0; j < 16; j++) v[127-8*j -: 8] = 8'(seed * 7 + j * 17 + 3);
        return v;
    endfunction

    // Runs one operation; left=1 store-left, 0 store-right, -1 illegal.
    // poke holds a competing start across the acknowledge and done cycles.
    task automatic run(input logic [31:0] ins, input logic [63:0] ra, input logic [63:0] rb,
                       input logic [127:0] vec, input int left, input int dly, input bit poke,
                       input bit to_mem, input logic [63:0] mbase, input string tag);
        logic [63:0]  ea;
        logic [3:0]   s;
        logic [15:0]  ebe;
        logic [127:0] edata;
        logic [15:0]  hbe;
        bit           expect_wr;
        ea = ((ins[20:16] == 5'd0) ? 64'd0 : ra) + rb;
        s = ea[3:0];
        for (int i = 0; i < 16; i++) begin
            ebe[i] = (left == 1) ? (i >= s) : (left == 0) ? (i < s) : 1'b0;
            edata[127-8*i -: 8] = vec[127-8*((i - int'(s)) & 15) -: 8];
        end
        expect_wr = (ebe != 16'd0);
        @(negedge clk);
        instr_i = ins; ra_val_i = ra; rb_val_i = rb; vr_data_i = vec; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        instr_i = enc_c(10'd647, 5'd1, 5'd0, 5'd0);
        chk(wr_req_o == expect_wr, {tag, " R5 R9 request"}, 128'(wr_req_o), 128'(expect_wr));
        if (wr_req_o) begin
            chk(wr_addr_o == {ea[63:4], 4'h0}, {tag, " R3 address"}, 128'(wr_addr_o), 128'({ea[63:4], 4'h0}));
            chk(wr_be_o == ebe, {tag, left == 1 ? " R4 left mask" : " R5 right mask"}, 128'(wr_be_o), 128'(ebe));
            chk(wr_data_o == edata, {tag, " R6 data"}, wr_data_o, edata);
            hbe = wr_be_o;
            for (int d = 0; d < dly; d++) begin
                @(negedge clk);
                chk(wr_req_o && wr_be_o == hbe, {tag, " R8 hold"}, 128'(wr_be_o), 128'(hbe));
            end
            if (to_mem) begin
                for (int i = 0; i < 16; i++)
                    if (wr_be_o[i]) begin
                        mem[int'(wr_addr_o - mbase) + i] = wr_data_o[127-8*i -: 8];
                        wcount[int'(wr_addr_o - mbase) + i]++;
                    end
            end
            wr_ack_i = 1'b1;
            if (poke) begin start_i = 1'b1; instr_i = enc_c(10'd647, 5'd2, 5'd0, 5'd0); end
            @(negedge clk);
            wr_ack_i = 1'b0;
        end
        chk(done_o == 1'b1, {tag, " R8 done"}, 128'(done_o), 128'd1);
        chk(illegal_o == (left < 0), {tag, " R9 illegal flag"}, 128'(illegal_o), 128'(left < 0));
        @(negedge clk);
        start_i = 1'b0;
        chk(done_o == 1'b0, {tag, " R8 done one cycle"}, 128'(done_o), 128'd0);
        if (poke) begin
            @(negedge clk);
            chk(!wr_req_o && !done_o, {tag, " R10 start ignored while busy"}, 128'({wr_req_o, done_o}), 128'd0);
        end
    endtask

    initial begin
        #200000;
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [9:0] cx [4];
        logic [6:0] ex [4];
        cx[0] = 10'd647; cx[1] = 10'd903; cx[2] = 10'd679; cx[3] = 10'd935;
        ex[0] = 7'd80;   ex[1] = 7'd112;  ex[2] = 7'd84;   ex[3] = 7'd116;
        repeat (3) @(negedge clk);
        chk(!wr_req_o && !done_o && !illegal_o, "reset outputs idle", 128'({wr_req_o, done_o, illegal_o}), 128'd0);
        rst_n = 1'b1;

        // R1 R2 R3: index outputs
        instr_i = enc_c(10'd647, 5'd19, 5'd7, 5'd12);
        #1;
        chk(vr_idx_o == 7'd19, "R1 classic vector index", 128'(vr_idx_o), 128'd19);
        chk(gpr_a_idx_o == 5'd7 && gpr_b_idx_o == 5'd12, "R3 gpr indices", 128'({gpr_a_idx_o, gpr_b_idx_o}), 128'({5'd7, 5'd12}));
        for (int v = 0; v < 128; v += 9) begin
            instr_i = enc_e(7'd84, 7'(v), 5'd3, 5'd4);
            #1;
            chk(vr_idx_o == 7'(v), "R2 extended vector index", 128'(vr_idx_o), 128'(v));
        end

        // R1 R2 R4 R5 R6 R7: full sweep of variants, encodings and offsets
        for (int f = 0; f < 2; f++)
            for (int k = 0; k < 4; k++)
                for (int s = 0; s < 16; s++) begin
                    logic [31:0] ins;
                    ins = (f == 0) ? enc_c(cx[k], 5'(s), 5'd5, 5'd6) : enc_e(ex[k], 7'(s * 8 + 3), 5'd5, 5'd6);
                    run(ins, 64'h0000_0000_0012_3400 + 64'(k * 256), 64'(s + 32 * f),
                        mkvec(s + k * 16 + f), (k < 2) ? 1 : 0, (s % 3), 1'b0, 1'b0, 64'd0,
                        f == 0 ? "R1 R7 classic" : "R2 R7 extended");
                end

        // R3: literal zero for base field 0, and 64-bit wrap
        run(enc_c(10'd647, 5'd1, 5'd0, 5'd9), 64'hDEAD_BEEF_0000_0000, 64'h0000_0000_0000_2005,
            mkvec(40), 1, 0, 1'b0, 1'b0, 64'd0, "R3 zero base");
        run(enc_e(7'd80, 7'd100, 5'd2, 5'd9), 64'hFFFF_FFFF_FFFF_FFF8, 64'h0000_0000_0000_0013,
            mkvec(41), 1, 1, 1'b0, 1'b0, 64'd0, "R3 wrap");

        // R9: unrecognised words
        run(enc_c(10'd231, 5'd1, 5'd2, 5'd3), 64'h100, 64'h5, mkvec(42), -1, 0, 1'b0, 1'b0, 64'd0, "R9 classic other xo");
        run(enc_e(7'd0, 7'd1, 5'd2, 5'd3), 64'h100, 64'h5, mkvec(43), -1, 0, 1'b0, 1'b0, 64'd0, "R9 extended other xo");
        run(enc_c(10'd647, 5'd1, 5'd2, 5'd3) | 32'h1, 64'h100, 64'h5, mkvec(44), -1, 0, 1'b0, 1'b0, 64'd0, "R9 record bit");

        // R10: competing start during acknowledge and done
        run(enc_c(10'd679, 5'd1, 5'd2, 5'd3), 64'h200, 64'h9, mkvec(45), 0, 2, 1'b1, 1'b0, 64'd0, "R10 right");
        run(enc_e(7'd80, 7'd77, 5'd2, 5'd3), 64'h200, 64'h4, mkvec(46), 1, 0, 1'b1, 1'b0, 64'd0, "R10 left");

        // R11: left at EA then right at EA+16 into a byte memory
        for (int s = 0; s < 16; s++) begin
            logic [127:0] v;
            bit           ok;
            v = mkvec(100 + s);
            for (int i = 0; i < 64; i++) begin mem[i] = 8'h00; wcount[i] = 0; end
            run(enc_c(10'd647, 5'd4, 5'd0, 5'd8), 64'd0, 64'h4000 + 64'(16 + s), v, 1, 0, 1'b0, 1'b1, 64'h4000, "R11 left");
            run(enc_e(7'd84, 7'd90, 5'd0, 5'd8), 64'd0, 64'h4000 + 64'(32 + s), v, 0, 1, 1'b0, 1'b1, 64'h4000, "R11 right");
            ok = 1;
            for (int j = 0; j < 16; j++)
                if (mem[16 + s + j] != v[127-8*j -: 8] || wcount[16 + s + j] != 1) ok = 0;
            for (int i = 0; i < 64; i++)
                if ((i < 16 + s || i >= 32 + s) && wcount[i] != 0) ok = 0;
            chk(ok, "R11 pair writes vector once at EA", 128'(ok), 128'd1);
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule